// File: doc/BRIEF.md
# Exception Entry and Mode Controller

This block decides which processor mode the core enters when an exception is requested, and which vector-table slot is fetched next. It takes software-interrupt, undefined-instruction, prefetch-abort and data-abort requests from the pipeline. It also takes two interrupt lines, a normal one and a fast one. When one of these is accepted, the block switches to the mode that belongs to that class of exception and updates the interrupt mask bits. It then gives the fetch unit a one-cycle redirect with the slot address, and gives the register file a one-cycle request to save the return address into the link register of the new mode.

The vector table is a row of single-instruction slots. Each slot is four bytes wide, and the slots start at the parameter `VEC_BASE`. Privileged software can rewrite the mode and mask fields through a direct status write port. That port is the only way to reach System mode. In User mode the port has no effect.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, the outputs show `cur_mode` = 5'b10011 (Supervisor), `irq_mask` = 1, `fiq_mask` = 1, `redirect_valid` = 0 and `save_lr` = 0. On the first clock edge with `rst` low, `redirect_valid` rises for one cycle with `redirect_addr` = `VEC_BASE` + 0x00 and `save_lr` = 0. Requests sampled at that edge are dropped.
- R2: An accepted request is sampled at a clock edge, and the outputs change at that same edge. Each class maps to a mode code and a slot offset from `VEC_BASE`, as follows:
  - software interrupt: Supervisor 10011, offset 0x08
  - undefined instruction: Undefined 11011, offset 0x04
  - prefetch abort: Abort 10111, offset 0x0C
  - data abort: Abort 10111, offset 0x10
  - normal interrupt: IRQ 10010, offset 0x18
  - fast interrupt: FIQ 10001, offset 0x1C
- R3: When several requests arrive together, only one is taken. The order from highest to lowest is: data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R4: Every exception entry sets `irq_mask`. A fast-interrupt entry also sets `fiq_mask`. Every other entry leaves `fiq_mask` unchanged.
- R5: `irq_line` is ignored while `irq_mask` = 1, and `fiq_line` is ignored while `fiq_mask` = 1. A line held high after its entry does not enter again.
- R6: Every exception entry raises `save_lr` and `redirect_valid` for exactly one cycle, provided no new request follows.
- R7: The status write port is laid out as follows: `sr_wr_data[4:0]` is the mode, bit 5 is the fast-interrupt mask and bit 6 is the normal-interrupt mask. A write from any privileged mode that carries one of the seven mode codes takes effect at the next edge. A write with any other mode code is ignored in full.
- R8: A status write issued while `cur_mode` = 5'b10000 (User) changes neither the mode nor the mask bits.
- R9: An exception accepted in the same cycle as a status write wins, and the write is discarded.
- R10: No exception enters System mode (5'b11111) or User mode. System mode is reached only through a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also starts the reset vector redirect |
| swi_req | input | 1 | Software-interrupt instruction executed |
| undef_req | input | 1 | Undefined instruction detected |
| pabt_req | input | 1 | Instruction fetch aborted |
| dabt_req | input | 1 | Data access aborted |
| irq_line | input | 1 | Normal interrupt request level |
| fiq_line | input | 1 | Fast interrupt request level |
| sr_wr_en | input | 1 | Direct status write strobe |
| sr_wr_data | input | 7 | Status write value: {I mask, F mask, mode[4:0]} |
| cur_mode | output | 5 | Current processor mode code |
| irq_mask | output | 1 | Normal interrupt masked |
| fiq_mask | output | 1 | Fast interrupt masked |
| redirect_valid | output | 1 | One-cycle strobe: fetch from redirect_addr |
| redirect_addr | output | ADDR_W | Vector slot address |
| save_lr | output | 1 | One-cycle request to save the return address in the new mode's link register |

## Verification
The main sweep tries all 64 combinations of the six request inputs. Each combination is tried under all four settings of the mask bits, starting from System mode. The bench predicts the winning class, the new mode, the masks and the slot address. This separates the priority order (R3) from the mode and slot mapping (R2), and a masked line losing from a line that would have won (R5).

Directed sequences cover the following cases:
- the reset redirect;
- a fast interrupt held high;
- writes from User mode and writes with invalid mode codes;
- a write that collides with an exception.

These show which of the two state-changing sources has precedence.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int SLOT_BYTES = 4;
    localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    // Enum value times SLOT_BYTES is the slot offset.
    typedef enum logic [2:0] {
        EXC_RESET = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_SWI   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_RSVD  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_e;

    typedef struct packed {
        logic dabt;
        logic fiq;
        logic irq;
        logic pabt;
        logic undef;
        logic swi;
    } req_t;

    typedef struct packed {
        logic valid;
        exc_e cls;
    } pick_t;

    // Same layout as the status write port.
    typedef struct packed {
        logic       i_mask;
        logic       f_mask;
        logic [4:0] mode;
    } psr_t;

    function automatic logic [4:0] mode_for(exc_e cls);
        case (cls)
            EXC_UNDEF:          return MODE_UND;
            EXC_PABT, EXC_DABT: return MODE_ABT;
            EXC_IRQ:            return MODE_IRQ;
            EXC_FIQ:            return MODE_FIQ;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic logic is_valid_mode(logic [4:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  req_t  req,
    input  logic  i_mask,
    input  logic  f_mask,
    output pick_t pick
);
    logic fiq_eff;
    logic irq_eff;

    assign fiq_eff = req.fiq & ~f_mask;
    assign irq_eff = req.irq & ~i_mask;

    always_comb begin
        pick = '{valid: 1'b1, cls: EXC_SWI};
        if (req.dabt)       pick.cls = EXC_DABT;
        else if (fiq_eff)   pick.cls = EXC_FIQ;
        else if (irq_eff)   pick.cls = EXC_IRQ;
        else if (req.pabt)  pick.cls = EXC_PABT;
        else if (req.undef) pick.cls = EXC_UNDEF;
        else if (req.swi)   pick.cls = EXC_SWI;
        else                pick.valid = 1'b0;
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  exc_e              cls,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam int PAD_W = ADDR_W - $bits(exc_e);

    logic [ADDR_W-1:0] offset;

    assign offset   = {{PAD_W{1'b0}}, cls} << SLOT_SHIFT;
    assign vec_addr = VEC_BASE + offset;
endmodule

// File: rtl/exc_mode_reg.sv
module exc_mode_reg
    import exc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pick_t pick,
    input  logic  wr_en,
    input  psr_t  wr_val,
    output psr_t  psr,
    output logic  redirect,
    output exc_e  redirect_cls,
    output logic  save_req
);
    logic boot_pending;
    logic wr_ok;

    assign wr_ok = wr_en && (psr.mode != MODE_USR) && is_valid_mode(wr_val.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            psr          <= '{i_mask: 1'b1, f_mask: 1'b1, mode: MODE_SVC};
            boot_pending <= 1'b1;
            redirect     <= 1'b0;
            save_req     <= 1'b0;
            redirect_cls <= EXC_RESET;
        end else begin
            boot_pending <= 1'b0;
            redirect     <= 1'b0;
            save_req     <= 1'b0;
            if (boot_pending) begin
                redirect     <= 1'b1;
                redirect_cls <= EXC_RESET;
            end else if (pick.valid) begin
                psr.mode     <= mode_for(pick.cls);
                psr.i_mask   <= 1'b1;
                if (pick.cls == EXC_FIQ) psr.f_mask <= 1'b1;
                redirect     <= 1'b1;
                save_req     <= 1'b1;
                redirect_cls <= pick.cls;
            end else if (wr_ok) begin
                psr <= wr_val;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              swi_req,
    input  logic              undef_req,
    input  logic              pabt_req,
    input  logic              dabt_req,
    input  logic              irq_line,
    input  logic              fiq_line,
    input  logic              sr_wr_en,
    input  logic [6:0]        sr_wr_data,
    output logic [4:0]        cur_mode,
    output logic              irq_mask,
    output logic              fiq_mask,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              save_lr
);
    req_t  req;
    pick_t pick;
    psr_t  psr;
    exc_e  cls_q;

    assign req = '{dabt: dabt_req, fiq: fiq_line, irq: irq_line,
                   pabt: pabt_req, undef: undef_req, swi: swi_req};

    exc_arbiter u_arb (
        .req    (req),
        .i_mask (psr.i_mask),
        .f_mask (psr.f_mask),
        .pick   (pick)
    );

    exc_mode_reg u_state (
        .clk          (clk),
        .rst          (rst),
        .pick         (pick),
        .wr_en        (sr_wr_en),
        .wr_val       (psr_t'(sr_wr_data)),
        .psr          (psr),
        .redirect     (redirect_valid),
        .redirect_cls (cls_q),
        .save_req     (save_lr)
    );

    exc_vector_gen #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_vec (
        .cls      (cls_q),
        .vec_addr (redirect_addr)
    );

    assign cur_mode = psr.mode;
    assign irq_mask = psr.i_mask;
    assign fiq_mask = psr.f_mask;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              swi_req,
    input logic              undef_req,
    input logic              pabt_req,
    input logic              dabt_req,
    input logic              irq_line,
    input logic              fiq_line,
    input logic              sr_wr_en,
    input logic [4:0]        cur_mode,
    input logic              irq_mask,
    input logic              fiq_mask,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_addr,
    input logic              save_lr
);
    logic sync_quiet;
    assign sync_quiet = !swi_req && !undef_req && !pabt_req && !dabt_req;

    p_entry_priv_r10: assert property (@(posedge clk) disable iff (rst)
        save_lr |-> (cur_mode != MODE_USR && cur_mode != MODE_SYS));

    p_fiq_masks_r4: assert property (@(posedge clk) disable iff (rst)
        (save_lr && cur_mode == MODE_FIQ) |-> (fiq_mask && irq_mask));

    p_irq_mask_set_r4: assert property (@(posedge clk) disable iff (rst)
        save_lr |-> irq_mask);

    p_save_with_redirect_r6: assert property (@(posedge clk) disable iff (rst)
        save_lr |-> redirect_valid);

    p_slot_align_r2: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (redirect_addr[1:0] == 2'b00));

    p_user_write_r8: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_en && cur_mode == MODE_USR && sync_quiet && !irq_line && !fiq_line)
        |=> (cur_mode == MODE_USR && $stable(irq_mask) && $stable(fiq_mask)));

    p_masked_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && irq_line && irq_mask && !fiq_line && sync_quiet)
        |=> !redirect_valid);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    localparam int          AW   = 32;
    localparam logic [31:0] BASE = 32'hFFFF_0000;
    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                           SYS = 5'b11111;

    logic clk = 1'b0;
    logic rst;
    logic swi_req, undef_req, pabt_req, dabt_req, irq_line, fiq_line, sr_wr_en;
    logic [6:0]  sr_wr_data;
    logic [4:0]  cur_mode;
    logic        irq_mask, fiq_mask, redirect_valid, save_lr;
    logic [31:0] redirect_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl #(.ADDR_W(AW), .VEC_BASE(BASE)) u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in;
        {swi_req, undef_req, pabt_req, dabt_req, irq_line, fiq_line, sr_wr_en} = '0;
        sr_wr_data = '0;
    endtask

    task automatic sr_write(logic [4:0] m, logic i, logic f);
        sr_wr_en   = 1'b1;
        sr_wr_data = {i, f, m};
        tick;
        sr_wr_en   = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary;
    end

    initial begin
        rst = 1'b1;
        clear_in;
        tick; tick; tick;
        check("R1 reset state", {cur_mode, irq_mask, fiq_mask, redirect_valid, save_lr},
              {SVC, 1'b1, 1'b1, 1'b0, 1'b0});
        rst = 1'b0;
        swi_req = 1'b1;
        tick;
        swi_req = 1'b0;
        check("R1 boot redirect", {redirect_valid, save_lr, cur_mode}, {1'b1, 1'b0, SVC});
        check("R1 boot address", redirect_addr, BASE);
        tick;
        check("R1 boot strobe one cycle", {redirect_valid, save_lr}, 2'b00);

        // Sweep: every request pattern under every mask setting, starting from System mode.
        for (int mk = 0; mk < 4; mk++) begin
            for (int p = 0; p < 64; p++) begin
                logic i0, f0, ent, ei, ef;
                logic [4:0]  em;
                logic [31:0] eo;
                string tag;
                i0 = mk[1];
                f0 = mk[0];
                sr_write(SYS, i0, f0);
                check("R7 privileged write", {cur_mode, irq_mask, fiq_mask}, {SYS, i0, f0});
                {dabt_req, fiq_line, irq_line, pabt_req, undef_req, swi_req} = p[5:0];
                tick;
                clear_in;
                ent = 1'b1; ef = f0;
                if (p[5])              begin em = ABT; eo = 32'h10; end
                else if (p[4] && !f0)  begin em = FIQ; eo = 32'h1C; ef = 1'b1; end
                else if (p[3] && !i0)  begin em = IRQ; eo = 32'h18; end
                else if (p[2])         begin em = ABT; eo = 32'h0C; end
                else if (p[1])         begin em = UND; eo = 32'h04; end
                else if (p[0])         begin em = SVC; eo = 32'h08; end
                else                   begin em = SYS; eo = 32'h0; ent = 1'b0; end
                ei = ent ? 1'b1 : i0;
                if ((p[4] && f0) || (p[3] && i0)) tag = "R5 masked line";
                else if ($countones(p[5:0]) > 1)  tag = "R3 priority";
                else                              tag = "R2 mode map";
                check(tag, {27'd0, cur_mode}, {27'd0, em});
                check("R4 mask update", {irq_mask, fiq_mask}, {ei, ef});
                check("R6 entry strobes", {redirect_valid, save_lr}, {ent, ent});
                if (ent) check("R2 slot address", redirect_addr, BASE + eo);
                tick;
                check("R6 strobes drop", {redirect_valid, save_lr}, 2'b00);
            end
        end

        // Fast interrupt held high: single entry.
        sr_write(SYS, 1'b0, 1'b0);
        fiq_line = 1'b1;
        tick;
        check("R5 held fiq enters", {cur_mode, redirect_valid}, {FIQ, 1'b1});
        tick;
        check("R5 held fiq ignored after mask", {cur_mode, redirect_valid}, {FIQ, 1'b0});
        tick;
        fiq_line = 1'b0;
        check("R5 held fiq still ignored", {redirect_valid, save_lr}, 2'b00);

        // User-mode writes.
        sr_write(USR, 1'b0, 1'b0);
        check("R7 write to user", {cur_mode, irq_mask, fiq_mask}, {USR, 2'b00});
        sr_write(SYS, 1'b1, 1'b1);
        check("R8 user write ignored", {cur_mode, irq_mask, fiq_mask}, {USR, 2'b00});
        swi_req = 1'b1;
        tick;
        swi_req = 1'b0;
        check("R10 swi from user", {cur_mode, irq_mask, fiq_mask, save_lr}, {SVC, 2'b10, 1'b1});

        // Invalid mode code ignored in full.
        sr_write(5'b00000, 1'b0, 1'b1);
        check("R7 invalid code ignored", {cur_mode, irq_mask, fiq_mask}, {SVC, 2'b10});

        // Exception beats a concurrent write.
        sr_write(SYS, 1'b0, 1'b0);
        check("R10 system by write", {27'd0, cur_mode}, {27'd0, SYS});
        sr_wr_en   = 1'b1;
        sr_wr_data = {1'b0, 1'b0, USR};
        undef_req  = 1'b1;
        tick;
        clear_in;
        check("R9 exception wins", {cur_mode, irq_mask, fiq_mask, redirect_valid},
              {UND, 2'b10, 1'b1});
        check("R9 slot", redirect_addr, BASE + 32'h04);

        summary;
    end
endmodule